// File: doc/BRIEF.md
# Second-Order Comb Decimation Filter

This block reduces the single-bit stream of a delta-sigma modulator to multi-bit words. Every enabled input sample goes through two cascaded running sums. Once per decimation period of M enabled samples, the second sum passes through two first-difference stages that work at the slow rate. The overall response is (1/M)^2 · (1 − z^-M)^2 / (1 − z^-1)^2, and the 1/M^2 scaling is left to the output shift and to the consumer of the word.

Configuration inputs choose the following:
- the rate M, from a fixed set that includes values which are not powers of two;
- whether a 0 bit counts as −1 or as 0;
- a right shift of the result;
- one of three processing styles: sums only (the differencing is done downstream), conversion-by-conversion (the sums restart after each word), or the full comb.

The 16-bit result is presented as two bytes with a one-cycle strobe. A write strobe aimed at the result bytes restarts all filter state.

Top module: `sinc2_decim`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `res_valid` is 0 and `res_hi`/`res_lo` are 0.
- R2: An input bit of 1 adds +1. An input bit of 0 adds −1 when `cfg_zero_neg`=1 and adds 0 when `cfg_zero_neg`=0.
- R3: `cfg_rate` codes 1..7 select M = 32, 50, 64, 125, 128, 250, 256. One result is produced for every M samples taken with `bit_en`=1, and cycles with `bit_en`=0 take no sample.
- R4: In full mode (`cfg_mode` 2 or 3) the result is the second difference of the second running sum, taken over one period. After a restart, a constant input of +1 gives M(M+1)/2 first and M^2 from then on.
- R5: In sums-only mode (`cfg_mode`=0) the result is the second running sum, including the M-th sample, and it is never restarted at a period boundary.
- R6: In conversion mode (`cfg_mode`=1) the result is the second running sum at the end of the period, and both sums restart from zero for the next period.
- R7: `cfg_shift` codes 0, 1, 2, 3 apply an arithmetic right shift of 0, 1, 2 or 4 bits. The low 16 bits of the shifted value follow, with bits 15:8 on `res_hi` and bits 7:0 on `res_lo`.
- R8: `res_valid` is high for exactly one cycle, the cycle after the clock edge that takes the M-th sample. The result bytes change only together with `res_valid`.
- R9: `res_wr`=1 clears both sums, the difference history and the sample counter, and it keeps the result bytes unchanged. If it coincides with a sample, that sample is dropped and no result appears for it.
- R10: With `cfg_rate`=0 no sample is taken: the counter and both sums hold, and `res_valid` stays 0.
- R11: The sums are 18-bit two's complement and wrap freely. The full-mode result stays M^2 during long runs even after the sums have wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Modulator output bit |
| bit_en | input | 1 | Sample enable for `bit_in` |
| cfg_mode | input | 2 | 0 sums only, 1 conversion, 2/3 full comb |
| cfg_rate | input | 3 | Decimation rate code, 0 = off |
| cfg_zero_neg | input | 1 | 1: a 0 bit counts −1; 0: a 0 bit counts 0 |
| cfg_shift | input | 2 | Output shift code (0,1,2,4 bits) |
| res_wr | input | 1 | Write strobe to the result bytes; clears the filter state |
| res_hi | output | 8 | Result bits 15:8 |
| res_lo | output | 8 | Result bits 7:0 |
| res_valid | output | 1 | One-cycle new-result strobe |

## Verification
The clear strobe and the period boundary can fall in the same cycle. Under that collision the clear must win: the sample is dropped, no strobe appears, and the next period counts from zero. The bench provokes this by feeding M−1 samples and then asserting `res_wr` together with the M-th sample. It then checks that no word appears. A following full period must yield the fresh-start value M(M+1)/2, and a stale or doubled sum would not give that value.

// File: rtl/sinc2_pkg.sv
package sinc2_pkg;

  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    MODE_SUMS  = 2'd0,
    MODE_CONV  = 2'd1,
    MODE_COMB  = 2'd2,
    MODE_COMB2 = 2'd3
  } mode_e;

  function automatic logic [CNT_W-1:0] rate_len(input logic [2:0] code);
    logic [CNT_W-1:0] len;
    case (code)
      3'd1:    len = CNT_W'(32);
      3'd2:    len = CNT_W'(50);
      3'd3:    len = CNT_W'(64);
      3'd4:    len = CNT_W'(125);
      3'd5:    len = CNT_W'(128);
      3'd6:    len = CNT_W'(250);
      3'd7:    len = CNT_W'(256);
      default: len = '0;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/sinc2_rate_ctr.sv
module sinc2_rate_ctr
  import sinc2_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic running;

  assign running = (len != '0);
  assign last    = take && running && (cnt >= len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (take && running) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sinc2_integ.sv
module sinc2_integ #(
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    take,
  input  logic                    dump,
  input  logic                    bit_in,
  input  logic                    zero_neg,
  output logic signed [ACC_W-1:0] sum2_nx
);

  logic signed [ACC_W-1:0] inc;
  logic signed [ACC_W-1:0] sum1;
  logic signed [ACC_W-1:0] sum2;
  logic signed [ACC_W-1:0] sum1_nx;

  always_comb begin
    if (bit_in)        inc = ACC_W'(1);
    else if (zero_neg) inc = '1;
    else               inc = '0;
  end

  assign sum1_nx = sum1 + inc;
  assign sum2_nx = sum2 + sum1_nx;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum1 <= '0;
      sum2 <= '0;
    end else if (take) begin
      if (dump) begin
        sum1 <= '0;
        sum2 <= '0;
      end else begin
        sum1 <= sum1_nx;
        sum2 <= sum2_nx;
      end
    end
  end

endmodule

// File: rtl/sinc2_comb.sv
module sinc2_comb
  import sinc2_pkg::*;
#(
  parameter int ACC_W = 18,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    fire,
  input  logic [1:0]              mode,
  input  logic [1:0]              shift_code,
  input  logic signed [ACC_W-1:0] sum2,
  output logic [OUT_W-1:0]        res,
  output logic                    valid
);

  logic signed [ACC_W-1:0] hist1;
  logic signed [ACC_W-1:0] hist2;
  logic signed [ACC_W-1:0] diff1;
  logic signed [ACC_W-1:0] diff2;
  logic signed [ACC_W-1:0] pick;
  logic signed [ACC_W-1:0] scaled;

  assign diff1 = sum2 - hist1;
  assign diff2 = diff1 - hist2;

  always_comb begin
    if (mode == MODE_COMB || mode == MODE_COMB2) pick = diff2;
    else                                         pick = sum2;
  end

  always_comb begin
    case (shift_code)
      2'd1:    scaled = pick >>> 1;
      2'd2:    scaled = pick >>> 2;
      2'd3:    scaled = pick >>> 4;
      default: scaled = pick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1 <= '0;
      hist2 <= '0;
      res   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= fire && !clr;
      if (clr) begin
        hist1 <= '0;
        hist2 <= '0;
      end else if (fire) begin
        hist1 <= sum2;
        hist2 <= diff1;
        res   <= scaled[OUT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/sinc2_decim.sv
module sinc2_decim
  import sinc2_pkg::*;
#(
  parameter int ACC_W = 18,
  parameter int OUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  input  logic                 bit_en,
  input  logic [1:0]           cfg_mode,
  input  logic [2:0]           cfg_rate,
  input  logic                 cfg_zero_neg,
  input  logic [1:0]           cfg_shift,
  input  logic                 res_wr,
  output logic [7:0]           res_hi,
  output logic [7:0]           res_lo,
  output logic                 res_valid
);

  localparam int BYTE_W = 8;

  logic [CNT_W-1:0]        len;
  logic [CNT_W-1:0]        cnt;
  logic                    last;
  logic                    take;
  logic                    fire;
  logic                    dump;
  logic signed [ACC_W-1:0] sum2_nx;
  logic [OUT_W-1:0]        res;

  assign len  = rate_len(cfg_rate);
  assign take = bit_en && (len != '0) && !res_wr;
  assign fire = last;
  assign dump = last && (cfg_mode == MODE_CONV);

  sinc2_rate_ctr u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (res_wr),
    .take (take),
    .len  (len),
    .cnt  (cnt),
    .last (last)
  );

  sinc2_integ #(.ACC_W(ACC_W)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .clr      (res_wr),
    .take     (take),
    .dump     (dump),
    .bit_in   (bit_in),
    .zero_neg (cfg_zero_neg),
    .sum2_nx  (sum2_nx)
  );

  sinc2_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_comb (
    .clk        (clk),
    .rst        (rst),
    .clr        (res_wr),
    .fire       (fire),
    .mode       (cfg_mode),
    .shift_code (cfg_shift),
    .sum2       (sum2_nx),
    .res        (res),
    .valid      (res_valid)
  );

  assign res_hi = res[OUT_W-1 -: BYTE_W];
  assign res_lo = res[BYTE_W-1:0];

endmodule

// File: rtl/sinc2_decim_chk.sv
module sinc2_decim_chk
  import sinc2_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             res_wr,
  input logic [2:0]       cfg_rate,
  input logic             res_valid,
  input logic [7:0]       res_hi,
  input logic [7:0]       res_lo,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable({res_hi, res_lo}));

  a_r9_clear_no_result: assert property (@(posedge clk) disable iff (rst)
    res_wr |=> !res_valid);

  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (cfg_rate == 3'd0) |=> !res_valid);

  a_r10_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
    ((len == '0) && !res_wr) |=> $stable(cnt));

  a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !res_wr && (len != '0) && (cnt < len - CNT_W'(1)))
      |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

bind sinc2_decim sinc2_decim_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .res_wr    (res_wr),
  .cfg_rate  (cfg_rate),
  .res_valid (res_valid),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .cnt       (cnt),
  .len       (len)
);

// File: tb/sim_sinc2_decim.sv
`timescale 1ns/1ps
module sim_sinc2_decim;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       bit_en = 1'b0;
  logic [1:0] cfg_mode = 2'd2;
  logic [2:0] cfg_rate = 3'd1;
  logic       cfg_zero_neg = 1'b0;
  logic [1:0] cfg_shift = 2'd0;
  logic       res_wr = 1'b0;
  logic [7:0] res_hi;
  logic [7:0] res_lo;
  logic       res_valid;

  int checks = 0;
  int fails = 0;
  int hold_err = 0;
  int pulse_err = 0;
  bit done = 1'b0;
  int got_q[$];
  logic [15:0] last_res = 16'h0;
  logic prev_valid = 1'b0;

  always #10 clk = ~clk;

  sinc2_decim u0 (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en),
    .cfg_mode(cfg_mode), .cfg_rate(cfg_rate), .cfg_zero_neg(cfg_zero_neg),
    .cfg_shift(cfg_shift), .res_wr(res_wr),
    .res_hi(res_hi), .res_lo(res_lo), .res_valid(res_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic en, input logic wr);
    @(negedge clk);
    if (res_valid) begin
      got_q.push_back(int'({res_hi, res_lo}));
      if (prev_valid) pulse_err++;
    end else if ({res_hi, res_lo} !== last_res) begin
      hold_err++;
    end
    prev_valid = res_valid;
    last_res = {res_hi, res_lo};
    bit_in = b; bit_en = en; res_wr = wr;
  endtask

  task automatic feed(input int n, input logic b);
    for (int i = 0; i < n; i++) step(b, 1'b1, 1'b0);
  endtask

  task automatic flush();
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic restart(input logic [1:0] m, input logic [2:0] r,
                         input logic neg, input logic [1:0] sh);
    cfg_mode = m; cfg_rate = r; cfg_zero_neg = neg; cfg_shift = sh;
    step(1'b0, 1'b0, 1'b1);
    flush();
    got_q.delete();
  endtask

  task automatic expect_words(input string req, input int n, input int first, input int rest);
    check({req, " count"}, got_q.size(), n);
    for (int i = 0; i < got_q.size() && i < n; i++)
      check(req, got_q[i], (i == 0 ? first : rest) & 16'hFFFF);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(res_valid), 0);
    check("R1 result", int'({res_hi, res_lo}), 0);
  endtask

  task automatic t_comb_ones();
    restart(2'd2, 3'd1, 1'b0, 2'd0);
    feed(96, 1'b1); flush();
    expect_words("R4 comb M=32", 3, 528, 1024);
  endtask

  task automatic t_neg_zeros();
    restart(2'd3, 3'd2, 1'b1, 2'd0);
    feed(150, 1'b0); flush();
    expect_words("R2 zero=-1 M=50", 3, -1275, -2500);
    restart(2'd2, 3'd2, 1'b0, 2'd0);
    feed(100, 1'b0); flush();
    expect_words("R2 zero=0", 2, 0, 0);
  endtask

  task automatic t_sums();
    restart(2'd0, 3'd3, 1'b0, 2'd0);
    feed(192, 1'b1); flush();
    check("R5 count", got_q.size(), 3);
    if (got_q.size() == 3) begin
      check("R5 sum k=1", got_q[0], 2080);
      check("R5 sum k=2", got_q[1], 8256);
      check("R5 sum k=3", got_q[2], 18528);
    end
  endtask

  task automatic t_conv();
    restart(2'd1, 3'd4, 1'b0, 2'd0);
    feed(250, 1'b1); flush();
    expect_words("R6 conv M=125", 2, 7875, 7875);
    restart(2'd1, 3'd6, 1'b0, 2'd0);
    feed(249, 1'b1); flush();
    check("R3 M=250 no early word", got_q.size(), 0);
    feed(1, 1'b1); flush();
    expect_words("R3 M=250 word", 1, 31375, 31375);
  endtask

  task automatic t_shift();
    restart(2'd2, 3'd5, 1'b0, 2'd3);
    feed(384, 1'b1);
    @(negedge clk);
    check("R7 hi byte", int'(res_hi), 8'h04);
    check("R7 lo byte", int'(res_lo), 8'h00);
    got_q.push_back(int'({res_hi, res_lo}));
    prev_valid = res_valid; last_res = {res_hi, res_lo};
    bit_en = 1'b0;
    expect_words("R7 shift4 M=128", 3, 516, 1024);
  endtask

  task automatic t_wrap();
    restart(2'd2, 3'd7, 1'b0, 2'd1);
    feed(1536, 1'b1); flush();
    expect_words("R11 wrap M=256", 6, 16448, 32768);
  endtask

  task automatic t_gaps();
    restart(2'd2, 3'd1, 1'b0, 2'd0);
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 1'b1, 1'b0);
      step(i[0], 1'b0, 1'b0);
    end
    flush();
    expect_words("R3 enable gaps", 1, 528, 528);
  endtask

  task automatic t_off();
    restart(2'd2, 3'd0, 1'b0, 2'd0);
    feed(100, 1'b1); flush();
    check("R10 off no word", got_q.size(), 0);
    cfg_rate = 3'd1;
    feed(32, 1'b1); flush();
    expect_words("R10 sums held", 1, 528, 528);
  endtask

  task automatic t_clear();
    restart(2'd2, 3'd1, 1'b0, 2'd0);
    feed(10, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    feed(32, 1'b1); flush();
    expect_words("R9 mid clear", 1, 528, 528);
  endtask

  task automatic t_collide();
    restart(2'd2, 3'd1, 1'b0, 2'd0);
    feed(31, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    flush();
    check("R9 clear wins", got_q.size(), 0);
    feed(32, 1'b1); flush();
    expect_words("R9 after collision", 1, 528, 528);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    last_res = {res_hi, res_lo};
    t_comb_ones();
    t_neg_zeros();
    t_sums();
    t_conv();
    t_shift();
    t_wrap();
    t_gaps();
    t_off();
    t_clear();
    t_collide();
    check("R8 result held between strobes", hold_err, 0);
    check("R8 strobe one cycle", pulse_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule